// File: doc/BRIEF.md
# Two-Wire Clock-Enable Control Slave

This block is a write-only slave on a two-wire serial bus. It holds three 8-bit control registers. Two of them carry one enable bit per clock output, for ten outputs. The third is a test-control register. A bus master addresses the slave and sends a command code byte and a byte count byte. The data bytes follow and fill the registers in order, starting at register 0. The enable bits and the leakage-test select are driven straight out to the clock output stage.

The block runs on a fast system clock. It oversamples the serial clock and data lines through a two-flop synchronizer, and it finds bus edges and start/stop conditions from the synchronized samples. It acknowledges by pulling the data line low through an open-drain style output, `sda_low_o`. The 7-bit device address is the parameter `DEV_ADDR`.

Top module: `tw_ctl_slave`

## Requirements
- R1: After reset, register 0 and register 1 read 8'hFF and register 2 reads 8'hC0. All ten clock enables are therefore 1, `leak_test_o` is 0 and `sda_low_o` is 0.
- R2: A start is SDATA falling while SCLK is high. A stop is SDATA rising while SCLK is high. A stop ends the transfer and releases the data line. A start always begins a new address phase.
- R3: The first byte after a start is the address: bits 7..1 are the device address and bit 0 is the direction, with 0 meaning write. The slave acknowledges only when the address equals `DEV_ADDR` and bit 0 is 0. Any other address byte gets no acknowledge, and then no later byte is acknowledged and no register changes until the next start.
- R4: For every accepted byte (address, command, count and data), `sda_low_o` goes high on the SCLK falling edge after the eighth bit. It goes low again on the SCLK falling edge after the ninth clock.
- R5: After the address, the slave takes one command code byte, whose value is ignored, and then one byte count byte. The data bytes that follow are written to register 0, then register 1, then register 2.
- R6: A data byte is written only if its index, counted from 0, is below both the byte count and 3. Data bytes past either limit are still acknowledged but are discarded.
- R7: In the enable vector, `clk_en_o[i]` equals register 0 bit (7-i) for i from 0 to 7. `clk_en_o[8]` equals register 1 bit 7 and `clk_en_o[9]` equals register 1 bit 6. A 1 enables the output.
- R8: `leak_test_o` is 1 when register 2 bit 7 is 0, which selects the PLL leakage test. It is 0 when that bit is 1, which leaves testing disabled.
- R9: Registers change only when a full eighth data bit has been received. A transfer cut short by a stop in the middle of a byte leaves every register unchanged.
- R10: A repeated start in the middle of a transfer drops that transfer. The transfer that follows the new start is decoded from its address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_low_o | output | 1 | 1 pulls the data line low (acknowledge) |
| r0_o | output | 8 | Register 0, enables for outputs 0..7 |
| r1_o | output | 8 | Register 1, enables for outputs 8..9 and reserved bits |
| r2_o | output | 8 | Register 2, test control |
| clk_en_o | output | 10 | Per-output clock enables |
| leak_test_o | output | 1 | PLL leakage test selected |

## Verification
Every bus input passes two synchronizer flops and one edge-detect flop. The acknowledge output therefore moves three system clocks after the SCLK falling edge that triggers it, and a register moves three clocks after the SCLK rising edge of a byte's eighth bit. The bench holds each SCLK phase for eight system clocks. It samples the acknowledge in the middle of the ninth high phase and checks that it is released one full low phase after the ninth clock. It compares the registers and the decoded outputs with its own model only after a stop plus several idle phases, so every check falls well past the three-cycle latency.

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] R0_INIT  = 8'hFF,
  parameter logic [7:0] R1_INIT  = 8'hFF,
  parameter logic [7:0] R2_INIT  = 8'hC0,
  parameter int         NOUT     = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_low_o,
  output logic [7:0]      r0_o,
  output logic [7:0]      r1_o,
  output logic [7:0]      r2_o,
  output logic [NOUT-1:0] clk_en_o,
  output logic            leak_test_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_DATA, S_SKIP} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bitn;
  logic [6:0] sh;
  logic [7:0] cnt_q, idx_q;
  logic       ack_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl       = scl_q[1];
  wire scl_d     = scl_q[2];
  wire sda       = sda_q[1];
  wire sda_d     = sda_q[2];
  wire scl_rise  = scl & ~scl_d;
  wire scl_fall  = ~scl & scl_d;
  wire start_c   = scl & scl_d & sda_d & ~sda;
  wire stop_c    = scl & scl_d & ~sda_d & sda;
  wire active    = (st != S_IDLE) && (st != S_SKIP);
  wire [7:0] byte_w = {sh, sda};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      bitn      <= '0;
      sh        <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      ack_pend  <= 1'b0;
      sda_low_o <= 1'b0;
      r0_o      <= R0_INIT;
      r1_o      <= R1_INIT;
      r2_o      <= R2_INIT;
    end else if (start_c) begin
      st        <= S_ADDR;
      bitn      <= '0;
      ack_pend  <= 1'b0;
      sda_low_o <= 1'b0;
    end else if (stop_c) begin
      st        <= S_IDLE;
      bitn      <= '0;
      ack_pend  <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      if (scl_fall) begin
        sda_low_o <= ack_pend;
        ack_pend  <= 1'b0;
      end
      if (scl_rise && active) begin
        if (bitn == 4'd8) begin
          bitn <= '0;
        end else begin
          sh   <= {sh[5:0], sda};
          bitn <= bitn + 4'd1;
          if (bitn == 4'd7) begin
            ack_pend <= 1'b1;
            case (st)
              S_ADDR:
                if (byte_w[7:1] == DEV_ADDR && !byte_w[0]) st <= S_CMD;
                else begin
                  st       <= S_SKIP;
                  ack_pend <= 1'b0;
                end
              S_CMD: st <= S_CNT;
              S_CNT: begin
                cnt_q <= byte_w;
                idx_q <= '0;
                st    <= S_DATA;
              end
              S_DATA: begin
                if (idx_q < cnt_q)
                  case (idx_q)
                    8'd0:    r0_o <= byte_w;
                    8'd1:    r1_o <= byte_w;
                    8'd2:    r2_o <= byte_w;
                    default: ;
                  endcase
                if (idx_q != 8'hFF) idx_q <= idx_q + 8'd1;
              end
              default: ;
            endcase
          end
        end
      end
    end

  for (genvar i = 0; i < 8; i++) begin : g_en0
    assign clk_en_o[i] = r0_o[7-i];
  end
  assign clk_en_o[8]  = r1_o[7];
  assign clk_en_o[9]  = r1_o[6];
  assign leak_test_o  = ~r2_o[7];

  p_ack_in_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> (st == S_CMD || st == S_CNT || st == S_DATA));

  p_ack_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_low_o);

  p_regs_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (r0_o != $past(r0_o) || r1_o != $past(r1_o) || r2_o != $past(r2_o)) |-> $past(scl_rise));

  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP && !start_c) |=> ($stable(r0_o) && $stable(r1_o) && $stable(r2_o) && !sda_low_o));

endmodule

// File: tb/tw_ctl_slave_tb.sv
module tw_ctl_slave_tb;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_low;
  logic [7:0] r0, r1, r2;
  logic [9:0] en;
  logic leak;
  wire  sda_line = sda_m & ~sda_low;

  int checks = 0, fails = 0;
  logic [7:0] exp_r [0:2];
  logic [7:0] dbuf [0:5];

  always #2 clk = ~clk;

  tw_ctl_slave #(.DEV_ADDR(ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_low_o(sda_low),
    .r0_o(r0), .r1_o(r1), .r2_o(r2), .clk_en_o(en), .leak_test_o(leak));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] en_model(input logic [7:0] a, input logic [7:0] b);
    logic [9:0] v;
    for (int i = 0; i < 8; i++) v[i] = a[7-i];
    v[8] = b[7];
    v[9] = b[6];
    return v;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic do_stop;
    scl = 1'b0; sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(4*Q);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; sda_m = b; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q/2);
    a = ~sda_line;
    wq(Q/2); scl = 1'b0; wq(Q);
    chk(a == exp_ack, {req, " R4 ack"}, a, exp_ack);
    chk(sda_low == 1'b0, "R4 release", sda_low, 0);
  endtask

  task automatic check_regs(input string req);
    chk(r0 == exp_r[0], {req, " reg0"}, r0, exp_r[0]);
    chk(r1 == exp_r[1], {req, " reg1"}, r1, exp_r[1]);
    chk(r2 == exp_r[2], {req, " reg2"}, r2, exp_r[2]);
    chk(en == en_model(exp_r[0], exp_r[1]), "R7 enable map", en, en_model(exp_r[0], exp_r[1]));
    chk(leak == ~exp_r[2][7], "R8 leak test", leak, ~exp_r[2][7]);
  endtask

  task automatic txn(input logic [6:0] a, input logic rw, input logic [7:0] cnt, input int n, input string req);
    bit m = (a == ADDR) && !rw;
    do_start;
    send_byte({a, rw}, m, req);
    send_byte(8'h00, m, req);
    send_byte(cnt, m, req);
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], m, req);
      if (m && i < 3 && i < cnt) exp_r[i] = dbuf[i];
    end
    do_stop;
    check_regs(req);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 180000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected < 180000", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_r[0] = 8'hFF; exp_r[1] = 8'hFF; exp_r[2] = 8'hC0;
    wq(5); rst_n = 1'b1; wq(5);
    chk(sda_low == 1'b0, "R1 sda idle", sda_low, 0);
    check_regs("R1");
    chk(en == 10'h3FF, "R1 all enabled", en, 10'h3FF);

    dbuf[0] = 8'hA5; dbuf[1] = 8'h80; dbuf[2] = 8'h40;
    txn(ADDR, 1'b0, 8'd3, 3, "R5");

    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    txn(ADDR ^ 7'h01, 1'b0, 8'd3, 3, "R3 mismatch");
    txn(ADDR, 1'b1, 8'd3, 3, "R3 read bit");

    dbuf[0] = 8'h3C; dbuf[1] = 8'h00; dbuf[2] = 8'h00;
    txn(ADDR, 1'b0, 8'd1, 3, "R6 count limit");

    for (int i = 0; i < 5; i++) dbuf[i] = 8'h50 + 8'(i);
    txn(ADDR, 1'b0, 8'd5, 5, "R6 past reg2");

    do_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R9");
    send_byte(8'h00, 1'b1, "R9");
    send_byte(8'd3, 1'b1, "R9");
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    do_stop;
    chk(sda_low == 1'b0, "R2 stop release", sda_low, 0);
    check_regs("R9 partial");

    do_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    scl = 1'b0; sda_m = 1'b1; wq(Q);
    dbuf[0] = 8'h0F; dbuf[1] = 8'hC0; dbuf[2] = 8'hC0;
    txn(ADDR, 1'b0, 8'd3, 3, "R10 restart");

    for (int k = 0; k < 30; k++) begin
      logic [6:0] a = ($urandom % 2) ? ADDR : 7'($urandom);
      logic rw = ($urandom % 4) == 0;
      int n = $urandom % 6;
      for (int i = 0; i < 6; i++) dbuf[i] = 8'($urandom);
      txn(a, rw, 8'($urandom % 6), n, "R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule